// File: doc/BRIEF.md
# Truncating 16-bit Float Multiplier

This block multiplies two 16-bit floating-point words. The format is the upper half of an IEEE single-precision word: a sign, an 8-bit biased exponent and 7 stored fraction bits. Each operand's significand is its hidden leading one with the 7 stored bits placed below it. The two 8-bit significands are multiplied into a 16-bit product. The block then normalises that product, adjusts the exponent and packs the truncated result back into the same 16-bit layout.

The arithmetic path is purely combinational and finishes within one clock cycle. A parameter selects whether a result register sits at the output or the combinational result is presented directly. A second parameter chooses how the significand product is built: with the multiply operator, or as a generated shift-and-add array of partial products.

There is no special-value handling. An operand with a zero exponent field counts as zero, and every other operand counts as a normal number. The block does not round.

Top module: `trunc_fmul`

## Requirements
- R1: Bit 15 of the result is the XOR of bit 15 of the two operands, for every operand pair, including zero, flushed and saturated results.
- R2: Words are laid out with the sign in bit 15, the exponent in bits 14:7 with bias 127, and the stored fraction in bits 6:0. When the 16-bit significand product is below 2.0 (bit 15 clear), the result exponent is ea+eb-127 and the fraction is product bits 13:7.
- R3: When the significand product has bit 15 set, the result exponent is ea+eb-126 and the fraction is product bits 14:8. The discarded low bits never cause an increment, so results are truncated.
- R4: If either operand has exponent field 0, bits 14:0 of the result are all zero.
- R5: If the adjusted exponent is below 1, bits 14:0 of the result are all zero. An adjusted exponent of exactly 1 is kept as a normal result.
- R6: If the adjusted exponent is above 255, the result exponent is 255 and the fraction is 0. An adjusted exponent of exactly 255 keeps its computed fraction.
- R7: For any operand pair, the result equals the exact real product of the two decoded values truncated to this format, with the R4 to R6 rules applied.
- R8: With OUT_REG=1 (the default), the result appears at the output on the first rising clock edge after the operands are applied and holds until the next edge. An active-low asynchronous reset clears the output to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| prod | output | 16 | Packed truncated product |

## Verification
The bench targets the point where the significand product crosses 2.0. A design that mishandles it gives results off by a factor of two, or fractions shifted by one bit. It also probes the exponent limits exactly at 1, 255, just below 1 and just above 255. An off-by-one comparison at those limits either flushes or saturates a valid result, or lets a wrapped exponent through. Operand pairs with all fraction bits set expose any rounding, because a rounding design returns a fraction one larger than the truncated reference. Zero-exponent operands and mixed signs check that zero results still carry the XOR sign rather than a cleared or copied one.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
   // Outcome of exponent adjustment for one multiply.
   typedef enum logic [1:0] {
      NRM_OK   = 2'd0,
      NRM_ZERO = 2'd1,
      NRM_UFL  = 2'd2,
      NRM_OFL  = 2'd3
   } nrm_class_e;
endpackage

// File: rtl/fmx_unpack.sv
module fmx_unpack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 7,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int SIG_W  = FRAC_W + 1
) (
   input  logic [WORD_W-1:0] word,
   output logic              sgn,
   output logic [EXP_W-1:0]  expo,
   output logic [SIG_W-1:0]  sig,
   output logic              is_zero
);
   always_comb begin
      sgn     = word[WORD_W-1];
      expo    = word[WORD_W-2 -: EXP_W];
      // hidden one is always present; zero operands are flagged separately
      sig     = {1'b1, word[FRAC_W-1:0]};
      is_zero = (expo == '0);
   end
endmodule

// File: rtl/fmx_sigmul.sv
module fmx_sigmul #(
   parameter int SIG_W     = 8,
   parameter int MUL_STYLE = 0,
   localparam int PROD_W = 2 * SIG_W
) (
   input  logic [SIG_W-1:0]  sig_a,
   input  logic [SIG_W-1:0]  sig_b,
   output logic [PROD_W-1:0] sig_p
);
   generate
      if (MUL_STYLE == 0) begin : g_op
         assign sig_p = PROD_W'(sig_a) * PROD_W'(sig_b);
      end else begin : g_array
         logic [PROD_W-1:0] acc [SIG_W+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < SIG_W; i++) begin : g_row
            logic [PROD_W-1:0] pp;
            assign pp         = sig_b[i] ? (PROD_W'(sig_a) << i) : '0;
            assign acc[i + 1] = acc[i] + pp;
         end
         assign sig_p = acc[SIG_W];
      end
   endgenerate
endmodule

// File: rtl/fmx_normpack.sv
module fmx_normpack
   import fmx_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 7,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int SIG_W  = FRAC_W + 1,
   localparam int PROD_W = 2 * SIG_W,
   localparam int EW     = EXP_W + 2,
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
   input  logic              sgn,
   input  logic [EXP_W-1:0]  exp_a,
   input  logic [EXP_W-1:0]  exp_b,
   input  logic              any_zero,
   input  logic [PROD_W-1:0] sig_p,
   output logic [WORD_W-1:0] result,
   output nrm_class_e        cls
);
   logic              carry;
   logic [FRAC_W-1:0] frac;
   logic [EW-1:0]     e_adj;
   logic              ufl, ofl;
   logic              unused_lo;

   assign carry     = sig_p[PROD_W-1];
   assign unused_lo = ^sig_p[FRAC_W-1:0];

   always_comb begin
      frac  = carry ? sig_p[PROD_W-2 -: FRAC_W] : sig_p[PROD_W-3 -: FRAC_W];
      // two guard bits: wrap below zero sets the top bit, >= 2^EXP_W sets the next
      e_adj = EW'(exp_a) + EW'(exp_b) - EW'(BIAS) + EW'(carry);
      ufl   = e_adj[EW-1] || (e_adj == '0);
      ofl   = !e_adj[EW-1] && e_adj[EW-2];
   end

   always_comb begin
      if (any_zero) begin
         cls    = NRM_ZERO;
         result = {sgn, {(WORD_W-1){1'b0}}};
      end else if (ufl) begin
         cls    = NRM_UFL;
         result = {sgn, {(WORD_W-1){1'b0}}};
      end else if (ofl) begin
         cls    = NRM_OFL;
         result = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else begin
         cls    = NRM_OK;
         result = {sgn, e_adj[EXP_W-1:0], frac};
      end
   end
endmodule

// File: rtl/trunc_fmul.sv
module trunc_fmul
   import fmx_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 7,
   parameter bit OUT_REG   = 1'b1,
   parameter int MUL_STYLE = 1,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int SIG_W  = FRAC_W + 1,
   localparam int PROD_W = 2 * SIG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic [WORD_W-1:0] prod
);
   initial begin
      assert (EXP_W >= 2 && EXP_W <= 15) else $error("EXP_W out of range");
      assert (FRAC_W >= 1 && FRAC_W <= 23) else $error("FRAC_W out of range");
      assert (MUL_STYLE == 0 || MUL_STYLE == 1) else $error("bad MUL_STYLE");
   end

   logic              sa, sb, za, zb;
   logic [EXP_W-1:0]  ea, eb;
   logic [SIG_W-1:0]  ma, mb;
   logic [PROD_W-1:0] sig_p;
   logic [WORD_W-1:0] res_c;
   nrm_class_e        cls;

   fmx_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
      .word(op_a), .sgn(sa), .expo(ea), .sig(ma), .is_zero(za));
   fmx_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
      .word(op_b), .sgn(sb), .expo(eb), .sig(mb), .is_zero(zb));

   fmx_sigmul #(.SIG_W(SIG_W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .sig_a(ma), .sig_b(mb), .sig_p(sig_p));

   fmx_normpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
      .sgn(sa ^ sb), .exp_a(ea), .exp_b(eb), .any_zero(za | zb),
      .sig_p(sig_p), .result(res_c), .cls(cls));

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod <= '0;
            else        prod <= res_c;
         end
      end else begin : g_comb
         assign prod = res_c;
      end
   endgenerate

   // R1: packed sign follows the operand signs
   p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
      res_c[WORD_W-1] == (op_a[WORD_W-1] ^ op_b[WORD_W-1]));

   // R3: two normal significands always give a leading one in the top two bits
   p_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_p[PROD_W-1] | sig_p[PROD_W-2]));

   // R4: a zero-exponent operand clears the magnitude
   p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a[WORD_W-2 -: EXP_W] == '0 || op_b[WORD_W-2 -: EXP_W] == '0)
      |-> res_c[WORD_W-2:0] == '0);

   // R5: an underflowing product carries no magnitude
   p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == NRM_UFL) |-> res_c[WORD_W-2:0] == '0);

   // R6: saturation gives all-ones exponent and empty fraction
   p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == NRM_OFL) |-> res_c[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

   generate
      if (OUT_REG) begin : g_reg_chk
         // R8: registered output lags the combinational result by one edge
         p_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> prod == $past(res_c));
      end
   endgenerate
endmodule

// File: tb/sim_trunc_fmul.sv
module sim_trunc_fmul;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = 16'h0000;
   logic [15:0] op_b = 16'h0000;
   logic [15:0] prod;
   int          n_vec = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   trunc_fmul u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod));

   // reference: exact real product, truncated into the 16-bit layout (R7)
   function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
      logic        s;
      real         va, vb, p;
      logic [63:0] bits;
      int          ex;
      s = a[15] ^ b[15];
      if (a[14:7] == 8'd0 || b[14:7] == 8'd0) return {s, 15'd0};
      va   = (1.0 + real'(a[6:0]) / 128.0) * $pow(2.0, real'(int'(a[14:7]) - 127));
      vb   = (1.0 + real'(b[6:0]) / 128.0) * $pow(2.0, real'(int'(b[14:7]) - 127));
      p    = va * vb;
      bits = $realtobits(p);
      ex   = int'(bits[62:52]) - 1023 + 127;
      if (ex < 1)   return {s, 15'd0};
      if (ex > 255) return {s, 8'hFF, 7'd0};
      return {s, ex[7:0], bits[51:45]};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp_v);
      n_vec++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, op_a, op_b, act, exp_v);
      end
   endtask

   // drive at falling edge, sample 1 ns after the capturing rising edge
   task automatic apply(input string req, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] exp_v);
      @(negedge clk);
      op_a = a;
      op_b = b;
      @(posedge clk);
      #1;
      check(req, prod, exp_v);
   endtask

   task automatic t_reset();
      op_a = 16'h4040;
      op_b = 16'h4040;
      repeat (2) @(negedge clk);
      check("R8 reset", prod, 16'h0000);
      rst_n = 1'b1;
   endtask

   task automatic t_basic();
      apply("R2 one", 16'h3F80, 16'h3F80, 16'h3F80);
      apply("R2 two*three", 16'h4000, 16'h4040, 16'h40C0);
      apply("R2 1.25*1.25", 16'h3FA0, 16'h3FA0, 16'h3FC8);
   endtask

   task automatic t_sign();
      apply("R1 neg*pos", 16'hC000, 16'h4040, 16'hC0C0);
      apply("R1 neg*neg", 16'hC000, 16'hC040, 16'h40C0);
      apply("R1 zero sign", 16'h8000, 16'h4040, 16'h8000);
   endtask

   task automatic t_norm();
      apply("R3 1.5*1.5", 16'h3FC0, 16'h3FC0, 16'h4010);
      apply("R3 max frac", 16'h3FFF, 16'h3FFF, ref_mul(16'h3FFF, 16'h3FFF));
      apply("R3 trunc", 16'h3FFF, 16'h3FFF, 16'h407E);
   endtask

   task automatic t_zero();
      apply("R4 a zero", 16'h0055, 16'h4040, 16'h0000);
      apply("R4 b zero", 16'hC0C0, 16'h007F, 16'h8000);
   endtask

   task automatic t_limits();
      apply("R5 flush", 16'h0080, 16'h0080, 16'h0000);
      apply("R5 edge one", 16'h0100, 16'h3F00, 16'h0080);
      apply("R5 neg flush", 16'h8080, 16'h3F00, 16'h8000);
      apply("R6 sat", 16'h7F80, 16'h7F80, 16'h7F80);
      apply("R6 edge 255", 16'h7F40, 16'h4000, 16'h7FC0);
      apply("R6 carry sat", 16'h7FC0, 16'h3FC0, 16'h7F80);
   endtask

   task automatic t_latency();
      apply("R8 load", 16'h4000, 16'h4000, 16'h4080);
      @(negedge clk);
      op_a = 16'h4040;
      #9;
      check("R8 hold", prod, 16'h4080);
      @(posedge clk);
      #1;
      check("R8 update", prod, 16'h40C0);
   endtask

   task automatic t_sweep();
      logic [31:0] x;
      x = 32'h1234_5678;
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a, b;
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         a = x[15:0];
         b = x[31:16];
         apply("R7 sweep", a, b, ref_mul(a, b));
      end
   endtask

   initial begin
      t_reset();
      t_basic();
      t_sign();
      t_norm();
      t_zero();
      t_limits();
      t_latency();
      t_sweep();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R8 actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule